// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Hazard Control

This block sits beside the decode and execute stages of a five-stage in-order RV32I pipeline. It looks at the instruction word held in the IF/ID register and decodes which register fields that word really reads and writes. It keeps a shadow of the register usage for the EX, MEM and WB stages. From that shadow it chooses, for each EX operand, the register file, the MEM result or the WB result. It raises a freeze when the instruction in decode needs a value that a load in EX has not yet fetched.

The execute stage reports a taken branch or a jump on `ex_redirect`. The block then squashes the two younger instructions on the wrong path, the one in IF/ID and the one about to enter ID/EX, which gives a two-cycle penalty. Branch compares and jump targets are computed in EX, so they use the same operand selection, and a load feeding them causes a freeze like any other consumer.

All pins are plain control signals sampled on the rising clock edge. There is no stream interface. A freeze means the fetch logic holds the PC and IF/ID, so the same word is presented again on the next cycle.

Top module: `pipe_hazard_unit`

## Requirements
- R1: An EX operand whose source register equals the destination of a register-writing instruction in MEM selects code 01 (MEM result).
- R2: An EX operand matching only a register-writing instruction in WB selects code 10 (WB result). With no match it selects 00 (register file), and code 11 never appears.
- R3: When MEM and WB both write the source register, MEM wins (code 01) because it holds the younger value.
- R4: A stage that does not write a register (store, branch, bubble) never supplies a forwarded value, even if the bits in its rd position match.
- R5: Register x0 is never forwarded and never causes a freeze, whether it is the source or the destination.
- R6: If a valid instruction in ID reads the destination of a load in EX, `freeze` and `bubble_idex` are 1 in that cycle. The next cycle EX holds a bubble. Once the held instruction reaches EX, it takes the load data from WB (code 10). An invalid ID slot never freezes.
- R7: Sources are decoded by opcode. rs2 bits [24:20] count only for R-type (0110011), store (0100011) and branch (1100011). rs1 bits [19:15] do not count for LUI, AUIPC and JAL. Immediate bits in those positions cause neither freeze nor forwarding.
- R8: A load that depends on a load freezes once, and the consumer of that second load freezes again. After both freezes its operands still resolve correctly.
- R9: In a cycle with `ex_redirect` high, `flush_ifid` and `bubble_idex` are 1. The instruction in ID never reaches EX, so the next cycle shows EX as a bubble (both selects 00).
- R10: Branch and jump (JALR) operands in EX are forwarded like any other operand. A branch reading a load result in EX freezes first.
- R11: Reset clears the EX/MEM/WB shadow: with `rst_n` low both selects read 00 and `freeze` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_instr | input | 32 | Instruction word in IF/ID |
| id_valid | input | 1 | IF/ID holds a real instruction |
| ex_redirect | input | 1 | Branch taken or jump resolved in EX |
| fwd_rs1_sel | output | 2 | EX rs1 source: 00 regfile, 01 MEM, 10 WB |
| fwd_rs2_sel | output | 2 | EX rs2 source: 00 regfile, 01 MEM, 10 WB |
| freeze | output | 1 | Hold PC and IF/ID for one cycle |
| flush_ifid | output | 1 | Turn IF/ID into a bubble |
| bubble_idex | output | 1 | Load a bubble into ID/EX |

## Verification
The assertions assume that `ex_redirect` is raised only while EX holds a branch or jump. Because of that, it can never coincide with a freeze, which always needs a load in EX. They also assume that after a freeze the fetch side presents the same word again. The stimulus table is written as a legal program trace: every frozen word is repeated in the next row, redirects are marked only on rows where a branch or JALR sits in EX, and wrong-path words follow each redirect.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int RIDX_W  = 5;
  localparam int INSTR_W = 32;

  localparam logic [6:0] OPC_LUI   = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;
  localparam logic [6:0] OPC_JAL   = 7'b1101111;
  localparam logic [6:0] OPC_JALR  = 7'b1100111;
  localparam logic [6:0] OPC_BR    = 7'b1100011;
  localparam logic [6:0] OPC_LD    = 7'b0000011;
  localparam logic [6:0] OPC_ST    = 7'b0100011;
  localparam logic [6:0] OPC_OPI   = 7'b0010011;
  localparam logic [6:0] OPC_OP    = 7'b0110011;

  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_MEM = 2'b01,
    SRC_WB  = 2'b10
  } src_sel_e;

  typedef struct packed {
    logic [RIDX_W-1:0] rs1;
    logic [RIDX_W-1:0] rs2;
    logic [RIDX_W-1:0] rd;
    logic              use1;
    logic              use2;
    logic              wr;
    logic              ld;
  } hz_slot_t;
endpackage

// File: rtl/hz_decode.sv
module hz_decode
  import hz_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  logic               valid,
  output hz_slot_t           slot
);
  logic [6:0] opc;
  logic u1, u2, w, l;

  assign opc = instr[6:0];

  always_comb begin
    u1 = 1'b0; u2 = 1'b0; w = 1'b0; l = 1'b0;
    unique case (opc)
      OPC_LUI, OPC_AUIPC, OPC_JAL: w = 1'b1;
      OPC_JALR, OPC_OPI:           begin u1 = 1'b1; w = 1'b1; end
      OPC_LD:                      begin u1 = 1'b1; w = 1'b1; l = 1'b1; end
      OPC_ST, OPC_BR:              begin u1 = 1'b1; u2 = 1'b1; end
      OPC_OP:                      begin u1 = 1'b1; u2 = 1'b1; w = 1'b1; end
      default: ;
    endcase
  end

  assign slot.rs1  = instr[19:15];
  assign slot.rs2  = instr[24:20];
  assign slot.rd   = instr[11:7];
  assign slot.use1 = valid & u1;
  assign slot.use2 = valid & u2;
  assign slot.wr   = valid & w;
  assign slot.ld   = valid & l;
endmodule

// File: rtl/hz_track.sv
module hz_track
  import hz_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  hz_slot_t id_slot,
  input  logic     squash,
  output hz_slot_t ex_slot,
  output hz_slot_t mem_slot,
  output hz_slot_t wb_slot
);
  localparam int DEPTH = 3;
  hz_slot_t stg [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= squash ? hz_slot_t'('0) : id_slot;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign ex_slot  = stg[0];
  assign mem_slot = stg[1];
  assign wb_slot  = stg[2];
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RIDX_W-1:0] src,
  input  logic              used,
  input  hz_slot_t          mem_slot,
  input  hz_slot_t          wb_slot,
  output logic [1:0]        sel
);
  logic hit_mem, hit_wb, live;

  assign live    = used && (src != '0);
  assign hit_mem = live && mem_slot.wr && (mem_slot.rd == src);
  assign hit_wb  = live && wb_slot.wr  && (wb_slot.rd  == src);

  always_comb begin
    if (hit_mem)     sel = SRC_MEM;
    else if (hit_wb) sel = SRC_WB;
    else             sel = SRC_RF;
  end

  // R5: the zero register is never taken from a later stage
  a_r5_zero_from_rf: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == SRC_RF));
  // R2: only three legal source codes
  a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    sel != 2'b11);
  // R4: a non-writing MEM stage never supplies data
  a_r4_mem_needs_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_MEM) |-> mem_slot.wr);
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hz_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] id_instr,
  input  logic               id_valid,
  input  logic               ex_redirect,
  output logic [1:0]         fwd_rs1_sel,
  output logic [1:0]         fwd_rs2_sel,
  output logic               freeze,
  output logic               flush_ifid,
  output logic               bubble_idex
);
  localparam int NOPS = 2;

  hz_slot_t id_slot, ex_slot, mem_slot, wb_slot;
  logic [1:0] sel [NOPS];
  logic load_rd_live, dep1, dep2;

  hz_decode u_dec (.instr(id_instr), .valid(id_valid), .slot(id_slot));

  hz_track u_trk (
    .clk(clk), .rst_n(rst_n), .id_slot(id_slot), .squash(bubble_idex),
    .ex_slot(ex_slot), .mem_slot(mem_slot), .wb_slot(wb_slot)
  );

  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    hz_fwd_pick u_pick (
      .clk(clk), .rst_n(rst_n),
      .src     (g == 0 ? ex_slot.rs1  : ex_slot.rs2),
      .used    (g == 0 ? ex_slot.use1 : ex_slot.use2),
      .mem_slot(mem_slot), .wb_slot(wb_slot),
      .sel     (sel[g])
    );
  end

  assign fwd_rs1_sel = sel[0];
  assign fwd_rs2_sel = sel[1];

  assign load_rd_live = ex_slot.ld && ex_slot.wr && (ex_slot.rd != '0);
  assign dep1 = id_slot.use1 && (id_slot.rs1 == ex_slot.rd);
  assign dep2 = id_slot.use2 && (id_slot.rs2 == ex_slot.rd);

  assign freeze      = load_rd_live && (dep1 || dep2);
  assign flush_ifid  = ex_redirect;
  assign bubble_idex = freeze || ex_redirect;

  // R6: the cycle after a freeze EX holds a bubble
  a_r6_freeze_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> (fwd_rs1_sel == SRC_RF && fwd_rs2_sel == SRC_RF && !freeze));
  // R9: the squashed ID word never shows up in EX
  a_r9_redirect_squash: assert property (@(posedge clk) disable iff (!rst_n)
    ex_redirect |=> (fwd_rs1_sel == SRC_RF && fwd_rs2_sel == SRC_RF && !freeze));
  // R9: a redirect (control op in EX) never meets a load freeze
  a_r9_no_freeze_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    ex_redirect |-> !freeze);
endmodule

// File: tb/pipe_hazard_unit_test.sv
module pipe_hazard_unit_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] id_instr = '0;
  logic id_valid = 1'b0;
  logic ex_redirect = 1'b0;
  logic [1:0] fwd_rs1_sel, fwd_rs2_sel;
  logic freeze, flush_ifid, bubble_idex;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  pipe_hazard_unit uut (
    .clk(clk), .rst_n(rst_n), .id_instr(id_instr), .id_valid(id_valid),
    .ex_redirect(ex_redirect), .fwd_rs1_sel(fwd_rs1_sel), .fwd_rs2_sel(fwd_rs2_sel),
    .freeze(freeze), .flush_ifid(flush_ifid), .bubble_idex(bubble_idex)
  );

  function automatic logic [31:0] e_r(int rd, int a, int b);
    return {7'd0, 5'(b), 5'(a), 3'd0, 5'(rd), 7'b0110011};
  endfunction
  function automatic logic [31:0] e_i(int rd, int a, int imm);
    return {12'(imm), 5'(a), 3'd0, 5'(rd), 7'b0010011};
  endfunction
  function automatic logic [31:0] e_ld(int rd, int a);
    return {12'd0, 5'(a), 3'b010, 5'(rd), 7'b0000011};
  endfunction
  function automatic logic [31:0] e_st(int b, int a, int imm);
    return {7'd0, 5'(b), 5'(a), 3'b010, 5'(imm), 7'b0100011};
  endfunction
  function automatic logic [31:0] e_br(int a, int b);
    return {7'd0, 5'(b), 5'(a), 3'd0, 5'd0, 7'b1100011};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic        v;
    logic        rdir;
    logic        fz;
    logic [1:0]  a;
    logic [1:0]  b;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{e_i(1,0,3),   1, 0, 0, 2'd0, 2'd0, 4'd11}, // 0
    '{e_i(1,1,1),   1, 0, 0, 2'd0, 2'd0, 4'd5},  // 1 R5 x0 read
    '{e_r(3,1,2),   1, 0, 0, 2'd1, 2'd0, 4'd1},  // 2 R1 MEM
    '{e_r(4,1,1),   1, 0, 0, 2'd1, 2'd0, 4'd3},  // 3 R3 MEM over WB
    '{e_st(3,0,4),  1, 0, 0, 2'd2, 2'd2, 4'd2},  // 4 R2 WB
    '{e_br(4,3),    1, 0, 0, 2'd0, 2'd2, 4'd2},  // 5 R2
    '{e_r(7,4,4),   1, 1, 0, 2'd2, 2'd0, 4'd4},  // 6 R4 store in MEM, R9 redirect
    '{e_i(8,0,0),   1, 0, 0, 2'd0, 2'd0, 4'd9},  // 7 R9 bubble in EX
    '{e_ld(0,2),    1, 0, 0, 2'd0, 2'd0, 4'd5},  // 8
    '{e_r(9,0,0),   1, 0, 0, 2'd0, 2'd0, 4'd5},  // 9 R5 load to x0
    '{e_ld(10,8),   1, 0, 0, 2'd0, 2'd0, 4'd5},  // 10 R5 x0 write
    '{e_i(12,12,10),1, 0, 0, 2'd0, 2'd0, 4'd7},  // 11 R7 fake rs2
    '{e_ld(13,10),  1, 0, 0, 2'd0, 2'd0, 4'd7},  // 12 R7
    '{e_ld(14,13),  1, 0, 1, 2'd2, 2'd0, 4'd8},  // 13 R8 first freeze
    '{e_ld(14,13),  1, 0, 0, 2'd0, 2'd0, 4'd6},  // 14 R6 bubble
    '{e_r(15,13,14),1, 0, 1, 2'd2, 2'd0, 4'd8},  // 15 R8 second freeze
    '{e_r(15,13,14),1, 0, 0, 2'd0, 2'd0, 4'd6},  // 16 R6
    '{e_ld(16,0),   1, 0, 0, 2'd0, 2'd2, 4'd8},  // 17 R8 resolved
    '{e_br(16,15),  1, 0, 1, 2'd0, 2'd0, 4'd10}, // 18 R10 load feeds branch
    '{e_br(16,15),  1, 0, 0, 2'd0, 2'd0, 4'd10}, // 19
    '{e_i(17,16,1), 1, 1, 0, 2'd2, 2'd0, 4'd10}, // 20 R10 branch fwd, redirect
    '{e_ld(18,0),   1, 0, 0, 2'd0, 2'd0, 4'd9},  // 21
    '{{7'd0,5'd18,5'd18,3'd0,5'd21,7'b0110111}, 1, 0, 0, 2'd0, 2'd0, 4'd7}, // 22 R7 lui
    '{{12'd18,5'd18,3'd0,5'd0,7'b1100111},      1, 0, 0, 2'd0, 2'd0, 4'd7}, // 23
    '{e_i(0,0,0),   1, 1, 0, 2'd2, 2'd0, 4'd10}, // 24 R10 jalr fwd
    '{e_ld(5,0),    1, 0, 0, 2'd0, 2'd0, 4'd9},  // 25
    '{e_r(6,5,5),   0, 0, 0, 2'd0, 2'd0, 4'd6},  // 26 R6 invalid slot
    '{e_r(6,5,5),   1, 0, 0, 2'd0, 2'd0, 4'd6},  // 27
    '{e_i(0,0,0),   1, 0, 0, 2'd2, 2'd2, 4'd6}   // 28 R6 WB data
  };

  task automatic chk(input int tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_P * 2000);
    bad++;
    $display("FAIL R0 watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    id_instr = e_r(1,1,1);
    id_valid = 1'b1;
    #(CLK_P/4);
    // R11 reset state
    chk(11, fwd_rs1_sel, 0, "reset rs1 sel");
    chk(11, fwd_rs2_sel, 0, "reset rs2 sel");
    chk(11, freeze, 0, "reset freeze");
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      id_instr    = VEC[k].ins;
      id_valid    = VEC[k].v;
      ex_redirect = VEC[k].rdir;
      #2;
      chk(VEC[k].tag, fwd_rs1_sel, VEC[k].a, $sformatf("v%0d rs1 sel", k));
      chk(VEC[k].tag, fwd_rs2_sel, VEC[k].b, $sformatf("v%0d rs2 sel", k));
      chk(VEC[k].tag, freeze, VEC[k].fz, $sformatf("v%0d freeze", k));
      chk(9, flush_ifid, VEC[k].rdir, $sformatf("v%0d flush", k));
      chk(9, bubble_idex, VEC[k].rdir | VEC[k].fz, $sformatf("v%0d bubble", k));
    end
    // R11 reset in mid-run clears forwarding state
    rst_n = 1'b0;
    #1;
    chk(11, fwd_rs1_sel, 0, "mid reset rs1 sel");
    chk(11, fwd_rs2_sel, 0, "mid reset rs2 sel");
    @(negedge clk); rst_n = 1'b1;
    id_instr = e_ld(9,0); id_valid = 1'b1;
    @(negedge clk);
    id_instr = e_r(2,0,9);
    #2;
    // R6 rs2 dependence on a load in EX
    chk(6, freeze, 1, "rs2 load-use freeze");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule